// File: doc/BRIEF.md
# Unpacked-to-binary32 Result Packer

This block takes one floating-point value in an unpacked working form and produces its IEEE-754 binary32 encoding, together with the overflow, underflow and inexact exception flags raised by that one conversion. The working form has five parts: a class tag, a sign, a signed unbiased exponent, a mantissa with an explicit leading one followed by extra fraction bits and two guard/round bits, and a separate sticky bit that stands for everything already discarded below the mantissa. Two control inputs accompany each value: a 2-bit rounding mode and an underflow-trap enable.

Normal results are aligned to 24 significant bits and rounded. A carry out of the rounding raises the exponent by one. Results whose biased exponent is zero or below are denormalized first and then rounded. Such a result may round up into the smallest normal number. Results too large for the format become infinity or the largest finite value, depending on the mode and the sign. Infinity, zero and NaN bypass rounding. A NaN keeps the upper bits of its payload.

Each value is accepted on a valid/ready handshake and comes out one cycle later from an output register. The result is held while the consumer stalls.

Top module: `fp32_packer`

## Requirements
- R1: A value of class zero (class code 0) produces the sign in bit 31 and zero in bits 30:0, with no flag raised.
- R2: A value of class infinity (class code 2) produces the sign, exponent field 255 and a zero fraction, with no flag raised.
- R3: A value of class NaN (class code 3) produces the sign and exponent field 255, and no flag is raised. Its fraction is the 23 mantissa bits just below the mantissa MSB, which keeps the quiet bit and the upper payload.
- R4: A number (class code 1, mantissa MSB set) whose biased exponent (unbiased + 127) is at least 1 is rounded to 24 significant bits. Mode codes: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. The inexact flag is set when any discarded bit or the sticky input is 1.
- R5: When normal rounding carries the significand to 2.0, the exponent field rises by one and the fraction becomes zero.
- R6: When the final biased exponent is 255 or more, overflow and inexact are set. The result is infinity in mode 0, in mode 2 with a positive sign and in mode 3 with a negative sign. In every other case it is exponent 254 with all fraction bits set.
- R7: When the biased exponent is 0 or less, the significand is shifted right by one extra place for each step below 1 and then rounded under the mode. The result has exponent field 0.
- R8: A subnormal that rounds up to 2^-126 produces exponent field 1 and a zero fraction, with inexact set and underflow clear.
- R9: A result that stays subnormal sets underflow when it is inexact, or in every case when the underflow trap enable is 1.
- R10: A value is accepted when in_valid and in_ready are both high. The result appears with out_valid on the next cycle. in_ready equals (not out_valid) or out_ready, and the result and flags stay unchanged while out_valid is high and out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Packer can accept a value |
| in_cls | input | 2 | Class: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | 10 | Signed unbiased exponent |
| in_mant | input | 29 | Leading one, 26 fraction bits, guard and round bits |
| in_sticky | input | 1 | OR of all bits discarded below the mantissa |
| rnd_mode | input | 2 | Rounding mode code |
| unf_trap_en | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 32 | binary32 encoding |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
On every cycle the assertions check four things: the output is held under back-pressure, a zero input gives a clean zero with no flags, a NaN input gives an all-ones exponent field, and the flags agree with the encoding (overflow always comes with inexact and a saturated exponent, and underflow always comes with exponent field 0). Those properties cannot show whether a rounding decision was correct, whether the right case was picked between infinity and the largest finite value, or whether a subnormal moved up to the smallest normal. The bench's sweeps show these. They run through every mode, sign, sticky value, trap setting, low mantissa pattern and boundary exponent, and compare each result with an integer quotient-and-remainder model.

// File: rtl/fp32_pack_pkg.sv
package fp32_pack_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } num_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_TOZERO  = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rnd_mode_e;

    localparam int SP_FRAC  = 23;
    localparam int SP_BIAS  = 127;
    localparam int SP_EMAX  = 255;
    localparam int KEEP_W   = SP_FRAC + 3;   // 24 significant bits + guard + round

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
        logic        ovf;
        logic        unf;
        logic        inx;
    } pack_out_s;

endpackage

// File: rtl/fp32_align_shr.sv
module fp32_align_shr #(
    parameter int MW = 29,
    parameter int OW = 26,
    parameter int SW = 5
) (
    input  logic [MW-1:0] mant,
    input  logic          sticky_in,
    input  logic [SW-1:0] shamt,
    output logic [OW-1:0] kept,
    output logic          sticky_out
);
    logic [MW-1:0] shifted;
    logic [MW-1:0] lost_mask;

    always_comb begin
        shifted    = mant >> shamt;
        lost_mask  = ~({MW{1'b1}} << shamt);
        kept       = shifted[OW-1:0];
        sticky_out = sticky_in | (|(mant & lost_mask));
    end
endmodule

// File: rtl/fp32_rnd_decide.sv
module fp32_rnd_decide
    import fp32_pack_pkg::*;
(
    input  logic [KEEP_W-1:0] kept,
    input  logic              sticky,
    input  logic              sign,
    input  logic [1:0]        mode,
    output logic [KEEP_W-2:0] sum,
    output logic              inexact
);
    logic guard_b, round_b, lsb_b, bump;

    always_comb begin
        guard_b = kept[1];
        round_b = kept[0];
        lsb_b   = kept[2];
        inexact = guard_b | round_b | sticky;
        unique case (rnd_mode_e'(mode))
            RM_NEAREST: bump = guard_b & (round_b | sticky | lsb_b);
            RM_TOZERO:  bump = 1'b0;
            RM_UP:      bump = inexact & ~sign;
            default:    bump = inexact & sign;
        endcase
        sum = {1'b0, kept[KEEP_W-1:2]} + {{(KEEP_W-2){1'b0}}, bump};
    end
endmodule

// File: rtl/fp32_packer.sv
module fp32_packer
    import fp32_pack_pkg::*;
#(
    parameter int EW = 10,
    parameter int IF = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_cls,
    input  logic          in_sign,
    input  logic [EW-1:0] in_exp,
    input  logic [IF+2:0] in_mant,
    input  logic          in_sticky,
    input  logic [1:0]    rnd_mode,
    input  logic          unf_trap_en,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [31:0]   out_word,
    output logic          out_ovf,
    output logic          out_unf,
    output logic          out_inx
);
    localparam int MW   = IF + 3;
    localparam int BW   = EW + 2;
    localparam int SW   = $clog2(MW + 1);
    localparam int BASE = MW - KEEP_W;

    pack_out_s st_d, st_q;

    logic              take;
    num_class_e        cls;
    logic [BW-1:0]     bexp_d;
    logic              is_sub_d;
    logic [BW-1:0]     sub_sh_d;
    logic [SW-1:0]     shamt_d;
    logic [KEEP_W-1:0] kept_d;
    logic              sticky_al_d;
    logic [KEEP_W-2:0] rsum_d;
    logic              rinx_d;
    logic [BW-1:0]     efin_d;
    logic              ovf_hit_d;
    logic              to_inf_d;

    assign cls      = num_class_e'(in_cls);
    assign in_ready = ~st_q.valid | out_ready;
    assign take     = in_valid & in_ready;

    always_comb begin
        bexp_d   = {{2{in_exp[EW-1]}}, in_exp} + BW'(SP_BIAS);
        is_sub_d = bexp_d[BW-1] | (bexp_d == '0);
        sub_sh_d = BW'(BASE + 1) - bexp_d;
        if (!is_sub_d)
            shamt_d = SW'(BASE);
        else if (sub_sh_d > BW'(MW))
            shamt_d = SW'(MW);
        else
            shamt_d = sub_sh_d[SW-1:0];
    end

    fp32_align_shr #(.MW(MW), .OW(KEEP_W), .SW(SW)) u_align (
        .mant       (in_mant),
        .sticky_in  (in_sticky),
        .shamt      (shamt_d),
        .kept       (kept_d),
        .sticky_out (sticky_al_d)
    );

    fp32_rnd_decide u_rnd (
        .kept    (kept_d),
        .sticky  (sticky_al_d),
        .sign    (in_sign),
        .mode    (rnd_mode),
        .sum     (rsum_d),
        .inexact (rinx_d)
    );

    always_comb begin
        efin_d    = bexp_d + {{(BW-1){1'b0}}, rsum_d[KEEP_W-2]};
        ovf_hit_d = ~efin_d[BW-1] & (efin_d >= BW'(SP_EMAX));
        unique case (rnd_mode_e'(rnd_mode))
            RM_NEAREST: to_inf_d = 1'b1;
            RM_TOZERO:  to_inf_d = 1'b0;
            RM_UP:      to_inf_d = ~in_sign;
            default:    to_inf_d = in_sign;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (out_ready)
            st_d.valid = 1'b0;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.ovf   = 1'b0;
            st_d.unf   = 1'b0;
            st_d.inx   = 1'b0;
            unique case (cls)
                CLS_ZERO: st_d.word = {in_sign, 31'd0};
                CLS_INF:  st_d.word = {in_sign, 8'hff, 23'd0};
                CLS_NAN:  st_d.word = {in_sign, 8'hff, in_mant[MW-2 -: SP_FRAC]};
                default: begin
                    st_d.inx = rinx_d;
                    if (is_sub_d) begin
                        if (rsum_d[SP_FRAC]) begin
                            st_d.word = {in_sign, 8'd1, 23'd0};
                        end else begin
                            st_d.word = {in_sign, 8'd0, rsum_d[SP_FRAC-1:0]};
                            st_d.unf  = rinx_d | unf_trap_en;
                        end
                    end else if (ovf_hit_d) begin
                        st_d.ovf  = 1'b1;
                        st_d.inx  = 1'b1;
                        st_d.word = to_inf_d ? {in_sign, 8'hff, 23'd0}
                                             : {in_sign, 8'hfe, 23'h7fffff};
                    end else begin
                        st_d.word = {in_sign, efin_d[7:0], rsum_d[SP_FRAC-1:0]};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_ovf   = st_q.ovf;
    assign out_unf   = st_q.unf;
    assign out_inx   = st_q.inx;

    // R10: a stalled result stays put
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_ovf)
                                       && $stable(out_unf) && $stable(out_inx)));

    // R1: zero class gives a clean zero with no flags
    a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == CLS_ZERO) |=> (out_word[30:0] == 31'd0 && !out_ovf && !out_unf && !out_inx));

    // R3: NaN keeps a saturated exponent field
    a_r3_nan_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cls == CLS_NAN) |=> (out_word[30:23] == 8'hff));

    // R6: overflow comes with inexact and a saturated encoding
    a_r6_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_inx && (out_word[30:23] == 8'hff
                                    || out_word[30:0] == {8'hfe, 23'h7fffff})));

    // R9: underflow only on a subnormal encoding
    a_r9_unf_exp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unf) |-> (out_word[30:23] == 8'd0));

    // R4: a number arrives with its leading one in the mantissa MSB
    a_r4_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_NUM) |-> in_mant[MW-1]);

endmodule

// File: tb/fp32_packer_bench.sv
module fp32_packer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 10;
    localparam int IF = 26;
    localparam int MW = IF + 3;
    localparam int DROP = MW - 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_cls = '0;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [MW-1:0] in_mant = '0;
    logic          in_sticky = 1'b0;
    logic [1:0]    rnd_mode = '0;
    logic          unf_trap_en = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [31:0]   out_word;
    logic          out_ovf, out_unf, out_inx;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp32_packer #(.EW(EW), .IF(IF)) u_fp32_packer (
        .clk, .rst_n, .in_valid, .in_ready, .in_cls, .in_sign, .in_exp, .in_mant,
        .in_sticky, .rnd_mode, .unf_trap_en, .out_valid, .out_ready,
        .out_word, .out_ovf, .out_unf, .out_inx
    );

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h flags %b, expected %h flags %b",
                     tag, got[34:3], got[2:0], exp[34:3], exp[2:0]);
        end
    endtask

    // Integer model: quotient/remainder by the result quantum.
    task automatic model(input int cls, input bit s, input int e, input longint unsigned m,
                         input bit st, input int mode, input bit trap,
                         output logic [31:0] w, output logic [2:0] fl, output string tag);
        longint unsigned q, rem, half, qr;
        int b, d, eb;
        bit inexact, up;
        fl = 3'b000;
        if (cls == 0) begin w = {s, 31'd0}; tag = "R1"; return; end
        if (cls == 2) begin w = {s, 8'hff, 23'd0}; tag = "R2"; return; end
        if (cls == 3) begin w = {s, 8'hff, 23'(m >> DROP)}; tag = "R3"; return; end
        b = e + 127;
        d = (b >= 1) ? DROP : DROP + (1 - b);
        q = m >> d;
        rem = m & ((64'd1 << d) - 1);
        half = 64'd1 << (d - 1);
        inexact = (rem != 0) || st;
        case (mode)
            0: up = (rem > half) || (rem == half && (st || q[0]));
            1: up = 1'b0;
            2: up = inexact && !s;
            default: up = inexact && s;
        endcase
        qr = q + 64'(up);
        if (b >= 1) begin
            eb = b;
            tag = "R4";
            if (qr >= 64'd1 << 24) begin eb = eb + 1; qr = qr >> 1; tag = "R5"; end
            if (eb >= 255) begin
                tag = "R6";
                fl = 3'b101;
                if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s))
                    w = {s, 8'hff, 23'd0};
                else
                    w = {s, 8'hfe, 23'h7fffff};
            end else begin
                w = {s, 8'(eb), 23'(qr)};
                fl = {2'b00, inexact};
            end
        end else if (qr >= 64'd1 << 23) begin
            tag = "R8";
            w = {s, 8'd1, 23'(qr - (64'd1 << 23))};
            fl = {2'b00, inexact};
        end else begin
            tag = (inexact || trap) ? "R9" : "R7";
            w = {s, 8'd0, 23'(qr)};
            fl = {1'b0, inexact || trap, inexact};
        end
    endtask

    task automatic run_one(input int cls, input bit s, input int e, input longint unsigned m,
                           input bit st, input int mode, input bit trap);
        logic [31:0] w;
        logic [2:0] fl;
        string tag;
        in_cls = 2'(cls); in_sign = s; in_exp = EW'(e); in_mant = MW'(m);
        in_sticky = st; rnd_mode = 2'(mode); unf_trap_en = trap; in_valid = 1'b1;
        @(negedge clk);
        model(cls, s, e, m, st, mode, trap, w, fl, tag);
        check({tag, " R10 valid"}, {34'd0, out_valid}, 35'd1);
        check(tag, {out_word, out_ovf, out_unf, out_inx}, {w, fl});
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int exps[12] = '{127, 128, 126, 0, -126, -127, -128, -130, -149, -150, -152, -170};
        logic [31:0] hold_w;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {34'd0, out_valid}, 35'd0);
        check("R10 reset ready", {34'd0, in_ready}, 35'd1);
        rst_n = 1'b1;

        // special classes R1 R2 R3
        foreach (exps[k]) if (k < 1) begin end
        for (int c = 0; c < 4; c++) begin
            if (c == 1) continue;
            for (int s = 0; s < 2; s++)
                for (int mode = 0; mode < 4; mode++)
                    for (int lo = 0; lo < 64; lo++)
                        run_one(c, 1'(s), lo - 20, (64'd1 << (MW-1)) | (64'(lo) << 17) | 64'(lo * 3),
                                1'(lo & 1), mode, 1'(lo >> 5));
        end

        // numbers: R4 R5 R6 R7 R8 R9
        for (int ei = 0; ei < 12; ei++)
            for (int up = 0; up < 2; up++)
                for (int mode = 0; mode < 4; mode++)
                    for (int s = 0; s < 2; s++)
                        for (int st = 0; st < 2; st++)
                            for (int tr = 0; tr < 2; tr++)
                                for (int lo = 0; lo < 64; lo++)
                                    run_one(1, 1'(s), exps[ei],
                                            (64'd1 << (MW-1)) | (up == 1 ? (((64'd1 << (MW-7)) - 1) << 6) : 64'd0) | 64'(lo),
                                            1'(st), mode, 1'(tr));

        // R10 back-pressure
        run_one(1, 1'b0, 3, 64'd1 << (MW-1), 1'b0, 0, 1'b0);
        hold_w = out_word;
        out_ready = 1'b0;
        in_cls = 2'd2; in_sign = 1'b1;
        @(negedge clk);
        check("R10 stall ready", {34'd0, in_ready}, 35'd0);
        check("R10 stall hold", {out_word, 2'b00, out_valid}, {hold_w, 3'b001});
        @(negedge clk);
        check("R10 stall hold 2", {out_word, 2'b00, out_valid}, {hold_w, 3'b001});
        out_ready = 1'b1;
        @(negedge clk);
        check("R10 resume", {out_word, 2'b00, out_valid}, {1'b1, 8'hff, 23'd0, 3'b001});
        in_valid = 1'b0;
        @(negedge clk);
        check("R10 drain", {34'd0, out_valid}, 35'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end
endmodule